// File: doc/BRIEF.md
# Periodic Tick Timer

This block produces the periodic system tick interrupt. It counts core clock cycles down from a reload count that software writes, and every time the count runs out it raises a sticky pending flag. An interrupt line is driven while that flag is set and the interrupt mask is off. Software reaches the block through a simple 32-bit register port. Each write takes effect on a single clock edge. Reads are combinational on the address.

To use it, software first writes the reload count, which is the core clock rate divided by the wanted tick rate. It then sets the run bit in the control register and clears the mask bit there. Each tick handler clears the pending flag by writing 0 to that flag's bit in the status register. A read-only revision register reports a fixed build value.

Top module: `tick_timer`

## Requirements
- R1: After reset, run is 0, mask is 1, pending is 0, the reload register reads 0, irq is 0, and the revision register reads the REVISION parameter (default 0x0001_0003).
- R2: The register offsets are revision 0x08 (read-only, writes ignored), control 0x10, status 0x20 and reload count 0x30 (all 32 bits written and read back). In control, bit 2 is run and bit 3 is mask; in status, bit 1 is pending. All other bits and all unmapped offsets read 0.
- R3: With reload N, the first expiry sets pending exactly max(N,1) clock edges after the edge that writes run from 0 to 1. Later expiries follow every max(N,1) edges.
- R4: Pending is sticky. Once set, it stays 1 until software clears it, even after many cycles with the timer stopped.
- R5: A write to status with bit 1 equal to 0 clears pending. A write with bit 1 equal to 1 leaves pending unchanged.
- R6: If an expiry and a clearing status write fall on the same edge, pending ends up 1.
- R7: irq is 1 exactly when pending is 1 and mask is 0.
- R8: Clearing run freezes the count, so no expiry happens while stopped. Setting run again restarts a full period from the reload value.
- R9: A control write that keeps run at 1 does not restart the current period.
- R10: A new reload value written while running takes effect at the next reload and does not shorten the current period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_wr | input | 1 | Write strobe, one write per clock edge while high |
| bus_addr | input | ADDR_W | Register byte offset for read and write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| irq | output | 1 | Tick interrupt, pending and not masked |

## Verification
The period is swept over reload counts 0 through 8. Counts 0 and 1 show the one-cycle floor, and the larger counts separate an exact N-edge period from an off-by-one. Each count is also run for a second period after a clear, to confirm that the block reloads. Separate sequences start, restart, stop and retarget the timer partway through a period. These tell a true freeze-and-restart apart from a free-running count, and an immediate reload apart from one that waits for the next expiry. A clear written on the expiry edge itself distinguishes event priority from clear priority.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;
  localparam int unsigned DATA_W = 32;

  // register offsets decoded by the bus port
  localparam logic [7:0] OFS_REV  = 8'h08;
  localparam logic [7:0] OFS_CTRL = 8'h10;
  localparam logic [7:0] OFS_STAT = 8'h20;
  localparam logic [7:0] OFS_LOAD = 8'h30;

  // field positions
  localparam int unsigned CTRL_RUN_BIT  = 2;
  localparam int unsigned CTRL_MASK_BIT = 3;
  localparam int unsigned STAT_PEND_BIT = 1;

  typedef struct packed {
    logic run;
    logic mask;
  } ctrl_t;
endpackage

// File: rtl/tt_rst_sync.sv
module tt_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  generate
    if (STAGES > 1) begin : g_chain
      always_comb sync_d = {sync_q[STAGES-2:0], 1'b1};
    end else begin : g_single
      always_comb sync_d = 1'b1;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/tt_regs.sv
module tt_regs
  import tick_timer_pkg::*;
#(
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned COUNT_W  = 32,
  parameter logic [31:0] REVISION = 32'h0001_0003
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_wr,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic [DATA_W-1:0]  bus_rdata,
  input  logic               pend,
  output ctrl_t              ctrl,
  output logic [COUNT_W-1:0] reload,
  output logic               start,
  output logic               clr_req
);
  localparam logic [ADDR_W-1:0] A_REV  = ADDR_W'(OFS_REV);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFS_CTRL);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFS_STAT);
  localparam logic [ADDR_W-1:0] A_LOAD = ADDR_W'(OFS_LOAD);

  logic               wr_ctrl, wr_stat, wr_load;
  ctrl_t              ctrl_q, ctrl_d;
  logic               ctrl_en;
  logic [COUNT_W-1:0] reload_q, reload_d;
  logic               reload_en;

  // write decode
  always_comb begin
    wr_ctrl = bus_wr && (bus_addr == A_CTRL);
    wr_stat = bus_wr && (bus_addr == A_STAT);
    wr_load = bus_wr && (bus_addr == A_LOAD);
  end

  // next state
  always_comb begin
    ctrl_en     = wr_ctrl;
    ctrl_d.run  = bus_wdata[CTRL_RUN_BIT];
    ctrl_d.mask = bus_wdata[CTRL_MASK_BIT];
    reload_en   = wr_load;
    reload_d    = bus_wdata[COUNT_W-1:0];
    start       = wr_ctrl && bus_wdata[CTRL_RUN_BIT] && !ctrl_q.run;
    clr_req     = wr_stat && !bus_wdata[STAT_PEND_BIT];
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q.run  <= 1'b0;
      ctrl_q.mask <= 1'b1;
    end else if (ctrl_en) begin
      ctrl_q <= ctrl_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         reload_q <= '0;
    else if (reload_en) reload_q <= reload_d;
  end

  // read mux
  always_comb begin
    bus_rdata = '0;
    unique case (bus_addr)
      A_REV:  bus_rdata = REVISION;
      A_CTRL: begin
        bus_rdata[CTRL_RUN_BIT]  = ctrl_q.run;
        bus_rdata[CTRL_MASK_BIT] = ctrl_q.mask;
      end
      A_STAT: bus_rdata[STAT_PEND_BIT] = pend;
      A_LOAD: bus_rdata = DATA_W'(reload_q);
      default: bus_rdata = '0;
    endcase
  end

  assign ctrl   = ctrl_q;
  assign reload = reload_q;

  AST_LOAD_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_load |=> reload_q == $past(bus_wdata[COUNT_W-1:0])); // R2
  AST_START_RUNS: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> ctrl_q.run); // R8
  AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wr |=> $stable(ctrl_q)); // R9
endmodule

// File: rtl/tt_counter.sv
module tt_counter #(
  parameter int unsigned COUNT_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run,
  input  logic               start,
  input  logic [COUNT_W-1:0] reload,
  output logic               expire
);
  logic [COUNT_W-1:0] cnt_q, cnt_d;
  logic               cnt_en;
  logic               at_end;

  always_comb begin
    at_end = (cnt_q <= COUNT_W'(1));
    cnt_en = start || run;
    expire = 1'b0;
    cnt_d  = cnt_q;
    if (start) begin
      cnt_d = reload;
    end else if (run) begin
      if (at_end) begin
        cnt_d  = reload;
        expire = 1'b1;
      end else begin
        cnt_d = cnt_q - COUNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  AST_RELOAD_ON_EXPIRE: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> cnt_q == $past(reload)); // R3
  AST_FROZEN_WHEN_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !start) |=> $stable(cnt_q)); // R8
  AST_NO_EXPIRE_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> !expire); // R8
endmodule

// File: rtl/tt_status.sv
module tt_status (
  input  logic clk,
  input  logic rst_n,
  input  logic expire,
  input  logic clr_req,
  input  logic mask,
  output logic pend,
  output logic irq
);
  logic pend_q, pend_d;

  always_comb begin
    pend_d = pend_q;
    if (expire)       pend_d = 1'b1;
    else if (clr_req) pend_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= pend_d;
  end

  assign pend = pend_q;
  assign irq  = pend_q && !mask;

  AST_EVENT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> pend_q); // R6
  AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_req && !expire) |=> !pend_q); // R5
  AST_PEND_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend_q) |-> $past(expire)); // R4
  AST_PEND_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !clr_req) |=> pend_q); // R4
endmodule

// File: rtl/tick_timer.sv
module tick_timer
  import tick_timer_pkg::*;
#(
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned COUNT_W  = 32,
  parameter logic [31:0] REVISION = 32'h0001_0003
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq
);
  logic               rst_int_n;
  ctrl_t              ctrl;
  logic [COUNT_W-1:0] reload;
  logic               start, clr_req, expire, pend;

  tt_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_int_n)
  );

  tt_regs #(.ADDR_W(ADDR_W), .COUNT_W(COUNT_W), .REVISION(REVISION)) u_regs (
    .clk(clk), .rst_n(rst_int_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pend(pend),
    .ctrl(ctrl), .reload(reload), .start(start), .clr_req(clr_req)
  );

  tt_counter #(.COUNT_W(COUNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_int_n), .run(ctrl.run), .start(start),
    .reload(reload), .expire(expire)
  );

  tt_status u_stat (
    .clk(clk), .rst_n(rst_int_n), .expire(expire), .clr_req(clr_req),
    .mask(ctrl.mask), .pend(pend), .irq(irq)
  );

  AST_IRQ_NEEDS_PEND: assert property (@(posedge clk) disable iff (!rst_int_n)
    irq |-> pend); // R7
  AST_MASK_SILENCES: assert property (@(posedge clk) disable iff (!rst_int_n)
    ctrl.mask |-> !irq); // R7
endmodule

// File: tb/tb_tick_timer.sv
module tb_tick_timer;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_wr;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  localparam logic [7:0] A_REV = 8'h08, A_CTRL = 8'h10, A_STAT = 8'h20, A_LOAD = 8'h30;
  localparam logic [31:0] RUN_UNMASK = 32'h4, STOP_MASK = 32'h8;

  always #5 clk = ~clk;

  tick_timer dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic check_reg(input string req, input logic [7:0] a, input logic [31:0] exp);
    bus_addr = a; #1;
    check(req, bus_rdata, exp);
  endtask

  task automatic check_pend(input string req, input logic exp);
    bus_addr = A_STAT; #1;
    check(req, {31'd0, bus_rdata[1]}, {31'd0, exp});
  endtask

  task automatic check_irq(input string req, input logic exp);
    #1;
    check(req, {31'd0, irq}, {31'd0, exp});
  endtask

  task automatic fresh_start(input logic [31:0] n);
    wr(A_CTRL, STOP_MASK);
    wr(A_STAT, 32'h0);
    wr(A_LOAD, n);
    wr(A_CTRL, RUN_UNMASK);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : stim
    rst_n = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    repeat (3) tick();
    rst_n = 1'b1;
    repeat (3) tick();

    // R1 reset state
    check_reg("R1 ctrl", A_CTRL, 32'h8);
    check_reg("R1 status", A_STAT, 32'h0);
    check_reg("R1 reload", A_LOAD, 32'h0);
    check_reg("R1 revision", A_REV, 32'h0001_0003);
    check_irq("R1 irq", 1'b0);

    // R2 map and field positions
    wr(A_LOAD, 32'hA5C3_1E7F);
    check_reg("R2 reload readback", A_LOAD, 32'hA5C3_1E7F);
    wr(A_REV, 32'hDEAD_BEEF);
    check_reg("R2 revision read-only", A_REV, 32'h0001_0003);
    check_reg("R2 unmapped", 8'h04, 32'h0);
    wr(A_CTRL, 32'hFFFF_FFF3);
    check_reg("R2 ctrl other bits", A_CTRL, 32'h0);
    wr(A_CTRL, 32'h8);
    check_reg("R2 ctrl mask bit3", A_CTRL, 32'h8);

    // R3 period sweep, R5 clear, R7 irq
    for (int n = 0; n <= 8; n++) begin
      int p;
      p = (n == 0) ? 1 : n;
      fresh_start(n);
      for (int j = 1; j < p; j++) begin
        tick();
        check_pend("R3 early", 1'b0);
        check_irq("R7 quiet", 1'b0);
      end
      tick();
      check_pend("R3 first expiry", 1'b1);
      check_irq("R7 asserted", 1'b1);
      if (p >= 2) begin
        wr(A_STAT, 32'h0);
        check_pend("R5 clear", 1'b0);
        for (int j = 0; j < p - 2; j++) tick();
        check_pend("R3 second early", 1'b0);
        tick();
        check_pend("R3 second expiry", 1'b1);
      end
    end

    // R8 stop freezes, restart gives full period
    fresh_start(5);
    repeat (2) tick();
    wr(A_CTRL, 32'h0);
    repeat (20) tick();
    check_pend("R8 stopped", 1'b0);
    wr(A_CTRL, RUN_UNMASK);
    repeat (4) tick();
    check_pend("R8 restart early", 1'b0);
    tick();
    check_pend("R8 restart expiry", 1'b1);

    // R9 control rewrite while running
    fresh_start(6);
    repeat (2) tick();
    wr(A_CTRL, RUN_UNMASK);
    repeat (2) tick();
    check_pend("R9 no restart early", 1'b0);
    tick();
    check_pend("R9 no restart expiry", 1'b1);

    // R6 expiry and clear on the same edge
    fresh_start(3);
    repeat (5) tick();
    check_pend("R6 pending before", 1'b1);
    wr(A_STAT, 32'h0);
    check_pend("R6 event wins", 1'b1);
    wr(A_STAT, 32'h0);
    check_pend("R5 clear after", 1'b0);

    // R10 reload change while running
    fresh_start(4);
    wr(A_LOAD, 32'd7);
    repeat (2) tick();
    check_pend("R10 old period early", 1'b0);
    tick();
    check_pend("R10 old period expiry", 1'b1);
    wr(A_STAT, 32'h0);
    repeat (5) tick();
    check_pend("R10 new period early", 1'b0);
    tick();
    check_pend("R10 new period expiry", 1'b1);

    // R4 sticky, R7 mask, R5 write-one ignored
    wr(A_CTRL, STOP_MASK);
    check_irq("R7 masked", 1'b0);
    repeat (30) tick();
    check_pend("R4 sticky", 1'b1);
    wr(A_STAT, 32'h2);
    check_pend("R5 write one ignored", 1'b1);
    wr(A_CTRL, 32'h0);
    check_irq("R7 unmasked", 1'b1);
    wr(A_STAT, 32'hFFFF_FFFD);
    check_pend("R5 clear other bits set", 1'b0);
    check_irq("R7 after clear", 1'b0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule